// File: doc/BRIEF.md
# Timestamp Status Frame Decoder

This block parses the payload of a status frame that a timestamping Ethernet PHY sends to report captured times. It accepts the payload one byte at a time with start-of-frame and end-of-frame markers, and discards the first two bytes. It then walks a chain of variable-length records. Each record opens with a 16-bit header: the top nibble gives the record type and the low 12 bits carry status. Receive-timestamp, transmit-timestamp and external-event records are decoded, and each one is presented as a single parallel record on a valid/ready output.

External-event records can be partial. A word-count field in the status says how many of the four time words are fresh, counted upward from the nanosecond low word. The block therefore keeps the last complete event time and merges each new record into it. Parsing stops at a record type it does not know. A frame that ends in the middle of a record raises a one-cycle error pulse and produces no record.

Top module: `tsframe_decoder`

## Requirements
- R1: After reset, `out_valid` and `err_trunc` are 0 and `in_ready` is 1. The retained event time is all zeros.
- R2: The first two bytes of each frame are skipped. The type nibble of the header (bits 15:12) selects the record: 0x2 is receive and `out_kind` is 0; 0x1 is transmit and `out_kind` is 1; 0x4 is event and `out_kind` is 2. Header bits 11:0 appear on `out_status`.
- R3: A receive record has six body words, in this order: ns low, ns high, sec low, sec high, sequence ID, and a tag word. The tag word carries the message type in bits 15:12 and the hash in bits 11:0. These words drive `out_ns`, `out_sec`, `out_seq`, `out_msg` and `out_hash`.
- R4: Bits 15:14 of the ns-high word are dropped. `out_ns` is {nshigh[13:0], nslow}, and `out_sec` is {sechigh, seclow}.
- R5: A transmit record has four body words (ns low, ns high, sec low, sec high). For transmit and event records, `out_seq`, `out_msg` and `out_hash` are 0.
- R6: An event record always has four body words. The word count in status bits 1:0 selects which retained words are replaced: 0 replaces ns low only, 1 also replaces ns high, 2 also replaces sec low, and 3 replaces all four. The output shows the merged time, and the merged time is retained for the next event.
- R7: With `big_endian` at 0, the first byte of each 16-bit word is the low byte. With `big_endian` at 1, the first byte is the high byte.
- R8: A header with any other type nibble ends parsing for the rest of the frame. No further records are produced and no error is raised. The next frame decodes normally.
- R9: If the frame ends after a known header but before that record's last body byte, `err_trunc` is high for one cycle. No record is produced and the retained event time is left unchanged. A single stray byte after a complete record is not an error.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record fields hold steady and `in_ready` is 0.
- R11: Several records in one frame come out in frame order. A byte marked start-of-frame restarts parsing at the preamble, and any record in progress is abandoned silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Word byte order: 1 = high byte first |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 2 | 0 receive, 1 transmit, 2 event |
| out_status | output | 12 | Header status bits |
| out_ns | output | 30 | Nanoseconds |
| out_sec | output | 32 | Seconds |
| out_seq | output | 16 | Sequence ID (receive only) |
| out_msg | output | 4 | Message type (receive only) |
| out_hash | output | 12 | Hash (receive only) |
| err_trunc | output | 1 | One-cycle pulse on a truncated record |

## Verification
The bench sets the overflow bits in the ns-high word. A decoder that kept them would report a nanosecond value above the 30-bit range. Event records are sent with every word count in turn, and the tests include a truncated event. A wrong merge would show stale or clobbered second or nanosecond words in later events. The bench also covers a frame that ends right after a known header, a stray trailing byte, an unknown type followed by a valid-looking record, and a start marker in the middle of a record. Each of these catches a decoder that emits phantom records, misses the error pulse, or raises it falsely. Big-endian transmit records expose swapped bytes, and a stalled consumer exposes a decoder that loses or overwrites a pending record.

// File: rtl/tsfd_pkg.sv
package tsfd_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int RX_WORDS = 6;
  localparam int TS_WORDS = 4;

  localparam logic [3:0] TYPE_EV = 4'h4;
  localparam logic [3:0] TYPE_RX = 4'h2;
  localparam logic [3:0] TYPE_TX = 4'h1;

  typedef enum logic [1:0] {
    KIND_RX = 2'd0,
    KIND_TX = 2'd1,
    KIND_EV = 2'd2
  } rec_kind_t;

  // number of body words following a header of the given type, 0 = unknown
  function automatic logic [2:0] body_words(input logic [3:0] t);
    case (t)
      TYPE_RX: body_words = 3'(RX_WORDS);
      TYPE_TX: body_words = 3'(TS_WORDS);
      TYPE_EV: body_words = 3'(TS_WORDS);
      default: body_words = 3'd0;
    endcase
  endfunction

  function automatic rec_kind_t kind_of(input logic [3:0] t);
    case (t)
      TYPE_RX: kind_of = KIND_RX;
      TYPE_TX: kind_of = KIND_TX;
      default: kind_of = KIND_EV;
    endcase
  endfunction

  // 30-bit nanoseconds: drop the two overflow flags of the high word
  function automatic logic [29:0] ns_of(input logic [15:0] hi, input logic [15:0] lo);
    ns_of = {hi[13:0], lo};
  endfunction

  // event word idx is refreshed when it lies at or below the word count
  function automatic logic word_fresh(input int idx, input logic [1:0] wc);
    word_fresh = (idx <= int'(wc));
  endfunction
endpackage

// File: rtl/tsfd_word_asm.sv
module tsfd_word_asm #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                sof,
  input  logic                eof,
  input  logic                big_endian,
  input  logic [BYTE_W-1:0]   data,
  output logic                word_stb,
  output logic [2*BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] held;
  logic              phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      phase <= 1'b0;
    end else if (fire) begin
      if (sof) begin
        held  <= data;
        phase <= 1'b1;
      end else if (eof) begin
        phase <= 1'b0;
      end else if (!phase) begin
        held  <= data;
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
      end
    end
  end

  assign word_stb = fire && !sof && phase;
  assign word     = big_endian ? {held, data} : {data, held};
endmodule

// File: rtl/tsfd_parser.sv
module tsfd_parser
  import tsfd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fire,
  input  logic                             sof,
  input  logic                             eof,
  input  logic                             word_stb,
  input  logic [WORD_W-1:0]                word,
  output logic                             rec_done,
  output rec_kind_t                        rec_kind,
  output logic [11:0]                      rec_status,
  output logic [MAX_WORDS-1:0][WORD_W-1:0] rec_words,
  output logic                             trunc
);
  localparam int IDX_W = $clog2(MAX_WORDS);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_HDR, ST_BODY, ST_HALT} pstate_t;

  pstate_t                         state, nxt;
  logic [IDX_W-1:0]                widx, last_idx;
  logic [MAX_WORDS-1:0][WORD_W-1:0] bufw;

  always_comb begin
    nxt      = state;
    rec_done = 1'b0;
    trunc    = 1'b0;
    if (fire) begin
      if (sof) begin
        nxt = eof ? ST_IDLE : ST_PRE;
      end else begin
        if (word_stb) begin
          case (state)
            ST_PRE: nxt = ST_HDR;
            ST_HDR: nxt = (body_words(word[15:12]) != 3'd0) ? ST_BODY : ST_HALT;
            ST_BODY: begin
              if (widx == last_idx) begin
                rec_done = 1'b1;
                nxt      = ST_HDR;
              end
            end
            default: ;
          endcase
        end
        if (eof) begin
          trunc = (nxt == ST_BODY);
          nxt   = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      widx       <= '0;
      last_idx   <= '0;
      rec_kind   <= KIND_RX;
      rec_status <= '0;
      bufw       <= '0;
    end else begin
      state <= nxt;
      if (word_stb && state == ST_HDR) begin
        rec_kind   <= kind_of(word[15:12]);
        rec_status <= word[11:0];
        last_idx   <= IDX_W'(body_words(word[15:12]) - 3'd1);
        widx       <= '0;
      end else if (word_stb && state == ST_BODY) begin
        bufw[widx] <= word;
        widx       <= widx + 1'b1;
      end
    end
  end

  // the final body word is presented straight from the assembler
  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++)
      rec_words[i] = (widx == IDX_W'(i)) ? word : bufw[i];
  end
endmodule

// File: rtl/tsfd_event_merge.sv
module tsfd_event_merge
  import tsfd_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd,
  input  logic [1:0]                   wc,
  input  logic [WORDS-1:0][WORD_W-1:0] fresh,
  output logic [WORDS-1:0][WORD_W-1:0] merged,
  output logic [WORDS-1:0][WORD_W-1:0] held
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign merged[g] = word_fresh(g, wc) ? fresh[g] : held[g];

    always_ff @(posedge clk) begin
      if (!rst_n)   held[g] <= '0;
      else if (upd) held[g] <= merged[g];
    end
  end
endmodule

// File: rtl/tsframe_decoder.sv
module tsframe_decoder
  import tsfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_kind,
  output logic [11:0] out_status,
  output logic [29:0] out_ns,
  output logic [31:0] out_sec,
  output logic [15:0] out_seq,
  output logic [3:0]  out_msg,
  output logic [11:0] out_hash,
  output logic        err_trunc
);
  logic                              fire, word_stb, rec_done, trunc, ev_upd;
  logic [WORD_W-1:0]                 word;
  rec_kind_t                         rec_kind;
  logic [11:0]                       rec_status;
  logic [RX_WORDS-1:0][WORD_W-1:0]   rec_words;
  logic [TS_WORDS-1:0][WORD_W-1:0]   ev_merged, ev_held, ts_sel;
  logic [1:0]                        ev_wc;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  tsfd_word_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(in_sof), .eof(in_eof),
    .big_endian(big_endian), .data(in_data), .word_stb(word_stb), .word(word)
  );

  tsfd_parser #(.WORD_W(WORD_W), .MAX_WORDS(RX_WORDS)) u_parse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(in_sof), .eof(in_eof),
    .word_stb(word_stb), .word(word), .rec_done(rec_done), .rec_kind(rec_kind),
    .rec_status(rec_status), .rec_words(rec_words), .trunc(trunc)
  );

  assign ev_wc  = rec_status[1:0];
  assign ev_upd = rec_done && rec_kind == KIND_EV;

  tsfd_event_merge #(.WORDS(TS_WORDS), .WORD_W(WORD_W)) u_ev (
    .clk(clk), .rst_n(rst_n), .upd(ev_upd), .wc(ev_wc),
    .fresh(rec_words[TS_WORDS-1:0]), .merged(ev_merged), .held(ev_held)
  );

  assign ts_sel = (rec_kind == KIND_EV) ? ev_merged : rec_words[TS_WORDS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_status <= '0;
      out_ns     <= '0;
      out_sec    <= '0;
      out_seq    <= '0;
      out_msg    <= '0;
      out_hash   <= '0;
      err_trunc  <= 1'b0;
    end else begin
      err_trunc <= trunc;
      if (rec_done) begin
        out_valid  <= 1'b1;
        out_kind   <= rec_kind;
        out_status <= rec_status;
        out_ns     <= ns_of(ts_sel[1], ts_sel[0]);
        out_sec    <= {ts_sel[3], ts_sel[2]};
        out_seq    <= (rec_kind == KIND_RX) ? rec_words[4] : '0;
        out_msg    <= (rec_kind == KIND_RX) ? rec_words[5][15:12] : '0;
        out_hash   <= (rec_kind == KIND_RX) ? rec_words[5][11:0] : '0;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsfd_checker.sv
module tsfd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic [11:0] out_status,
  input logic [29:0] out_ns,
  input logic [31:0] out_sec,
  input logic [15:0] out_seq,
  input logic [3:0]  out_msg,
  input logic [11:0] out_hash,
  input logic        err_trunc,
  input logic        ev_upd,
  input logic [1:0]  ev_wc,
  input logic [15:0] ev_top
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ns) && $stable(out_sec)
                                   && $stable(out_kind) && $stable(out_status)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind != 2'd3));

  p_rxonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd0) |-> (out_seq == 16'd0 && out_msg == 4'd0 && out_hash == 12'd0));

  p_norec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_trunc |-> !$rose(out_valid));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_trunc |=> !err_trunc);

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_upd && ev_wc != 2'd3) |=> $stable(ev_top));
endmodule

bind tsframe_decoder tsfd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_status(out_status),
  .out_ns(out_ns), .out_sec(out_sec), .out_seq(out_seq), .out_msg(out_msg),
  .out_hash(out_hash), .err_trunc(err_trunc), .ev_upd(ev_upd), .ev_wc(ev_wc),
  .ev_top(ev_held[3])
);

// File: tb/tsframe_decoder_test.sv
module tsframe_decoder_test;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [11:0] out_status;
  logic [29:0] out_ns;
  logic [31:0] out_sec;
  logic [15:0] out_seq;
  logic [3:0]  out_msg;
  logic [11:0] out_hash;
  logic        err_trunc;

  tsframe_decoder uut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_status(out_status), .out_ns(out_ns), .out_sec(out_sec), .out_seq(out_seq),
    .out_msg(out_msg), .out_hash(out_hash), .err_trunc(err_trunc)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // frame under construction
  logic [7:0] fb[0:63];
  logic       fs[0:63];
  int         flen;

  // captured records
  logic [1:0]  r_kind[0:15];
  logic [11:0] r_stat[0:15];
  logic [29:0] r_ns[0:15];
  logic [31:0] r_sec[0:15];
  logic [15:0] r_seq[0:15];
  logic [3:0]  r_msg[0:15];
  logic [11:0] r_hash[0:15];
  int          n_rec = 0;
  int          n_trunc = 0;

  // bench model of the retained event time
  logic [15:0] ev_m[0:3];

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && n_rec < 16) begin
      r_kind[n_rec] = out_kind;  r_stat[n_rec] = out_status;
      r_ns[n_rec]   = out_ns;    r_sec[n_rec]  = out_sec;
      r_seq[n_rec]  = out_seq;   r_msg[n_rec]  = out_msg;
      r_hash[n_rec] = out_hash;  n_rec++;
    end
    if (rst_n && err_trunc) n_trunc++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic fclear();
    flen = 0;
    n_rec = 0;
    n_trunc = 0;
  endtask

  task automatic fbyte(input logic [7:0] b);
    fb[flen] = b;
    fs[flen] = (flen == 0);
    flen++;
  endtask

  task automatic fword(input logic [15:0] w);
    if (big_endian) begin fbyte(w[15:8]); fbyte(w[7:0]); end
    else begin fbyte(w[7:0]); fbyte(w[15:8]); end
  endtask

  task automatic fhdr(input logic [3:0] t, input logic [11:0] st);
    fword({t, st});
  endtask

  task automatic fpre();
    fbyte(8'h5A);
    fbyte(8'hC3);
  endtask

  task automatic send_frame();
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = fs[i];
      in_eof   = (i == flen - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [29:0] exp_ns(input logic [15:0] hi, input logic [15:0] lo);
    logic [31:0] full;
    full = {hi, lo} & 32'h3FFF_FFFF;
    return full[29:0];
  endfunction

  // model update for an event record: words 0..wc replaced
  task automatic ev_apply(input logic [1:0] wc, input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2, input logic [15:0] w3);
    ev_m[0] = w0;
    if (wc >= 2'd1) ev_m[1] = w1;
    if (wc >= 2'd2) ev_m[2] = w2;
    if (wc == 2'd3) ev_m[3] = w3;
  endtask

  task automatic t_reset();
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 err_trunc after reset", err_trunc, 0);
    chk("R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_rx_little();
    big_endian = 1'b0;
    fclear(); fpre(); fhdr(4'h2, 12'h123);
    fword(16'hBEEF); fword(16'hC123); fword(16'h5678); fword(16'h9ABC);
    fword(16'h0042); fword(16'h7ABC);
    send_frame();
    chk("R3 rx record count", n_rec, 1);
    chk("R2 rx kind", r_kind[0], 0);
    chk("R2 rx status", r_stat[0], 12'h123);
    chk("R4 rx ns overflow bits dropped", r_ns[0], exp_ns(16'hC123, 16'hBEEF));
    chk("R4 rx sec", r_sec[0], 32'h9ABC_5678);
    chk("R3 rx seq", r_seq[0], 16'h0042);
    chk("R3 rx msg", r_msg[0], 4'h7);
    chk("R3 rx hash", r_hash[0], 12'hABC);
    chk("R9 no error on full rx", n_trunc, 0);
  endtask

  task automatic t_tx_big();
    big_endian = 1'b1;
    fclear(); fpre(); fhdr(4'h1, 12'h0A5);
    fword(16'h1111); fword(16'h4222); fword(16'h3333); fword(16'h4444);
    send_frame();
    chk("R5 tx record count", n_rec, 1);
    chk("R2 tx kind", r_kind[0], 1);
    chk("R7 tx big-endian ns", r_ns[0], exp_ns(16'h4222, 16'h1111));
    chk("R7 tx big-endian sec", r_sec[0], 32'h4444_3333);
    chk("R5 tx seq zero", r_seq[0], 0);
    chk("R5 tx hash zero", r_hash[0], 0);
    chk("R2 tx status", r_stat[0], 12'h0A5);
    big_endian = 1'b0;
  endtask

  task automatic t_event(input logic [11:0] st, input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3, input string tag);
    fclear(); fpre(); fhdr(4'h4, st);
    fword(w0); fword(w1); fword(w2); fword(w3);
    send_frame();
    ev_apply(st[1:0], w0, w1, w2, w3);
    chk({"R6 event count ", tag}, n_rec, 1);
    chk({"R2 event kind ", tag}, r_kind[0], 2);
    chk({"R6 event ns ", tag}, r_ns[0], exp_ns(ev_m[1], ev_m[0]));
    chk({"R6 event sec ", tag}, r_sec[0], {ev_m[3], ev_m[2]});
  endtask

  task automatic t_events();
    for (int i = 0; i < 4; i++) ev_m[i] = 16'h0000;
    t_event(12'h000, 16'h0A01, 16'h0B02, 16'h0C03, 16'h0D04, "wc0 from reset");
    t_event(12'h003, 16'h1A01, 16'h1B02, 16'h1C03, 16'h1D04, "wc3");
    t_event(12'h000, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "wc0");
    t_event(12'h7F1, 16'h5555, 16'h6666, 16'h7777, 16'h8888, "wc1");
    t_event(12'h002, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC, "wc2");
  endtask

  task automatic t_multi();
    fclear(); fpre();
    fhdr(4'h1, 12'h010); fword(16'h0001); fword(16'h0002); fword(16'h0003); fword(16'h0004);
    fhdr(4'h2, 12'h020); fword(16'h0011); fword(16'h0012); fword(16'h0013); fword(16'h0014);
    fword(16'h0015); fword(16'h3016);
    fhdr(4'h4, 12'h003); fword(16'h0021); fword(16'h0022); fword(16'h0023); fword(16'h0024);
    send_frame();
    ev_apply(2'd3, 16'h0021, 16'h0022, 16'h0023, 16'h0024);
    chk("R11 multi record count", n_rec, 3);
    chk("R11 multi first kind", r_kind[0], 1);
    chk("R11 multi second kind", r_kind[1], 0);
    chk("R11 multi third kind", r_kind[2], 2);
    chk("R11 multi second seq", r_seq[1], 16'h0015);
    chk("R11 multi third sec", r_sec[2], 32'h0024_0023);
  endtask

  task automatic t_unknown();
    fclear(); fpre(); fhdr(4'h3, 12'h000);
    fhdr(4'h1, 12'h000); fword(16'hAAAA); fword(16'hBBBB); fword(16'hCCCC); fword(16'hDDDD);
    send_frame();
    chk("R8 unknown type no records", n_rec, 0);
    chk("R8 unknown type no error", n_trunc, 0);
    fclear(); fpre(); fhdr(4'h1, 12'h001);
    fword(16'h0101); fword(16'h0202); fword(16'h0303); fword(16'h0404);
    send_frame();
    chk("R8 next frame decodes", n_rec, 1);
    chk("R8 next frame sec", r_sec[0], 32'h0404_0303);
  endtask

  task automatic t_trunc();
    fclear(); fpre(); fhdr(4'h2, 12'h000); fword(16'h1234); fword(16'h2345); fword(16'h3456);
    send_frame();
    chk("R9 truncated rx error pulse", n_trunc, 1);
    chk("R9 truncated rx no record", n_rec, 0);
    fclear(); fpre(); fhdr(4'h1, 12'h000);
    send_frame();
    chk("R9 header-only error pulse", n_trunc, 1);
    chk("R9 header-only no record", n_rec, 0);
    fclear(); fpre(); fhdr(4'h4, 12'h003); fword(16'hDEAD); fword(16'hBEEF);
    send_frame();
    chk("R9 truncated event error", n_trunc, 1);
    t_event(12'h000, 16'h0F0F, 16'h1E1E, 16'h2D2D, 16'h3C3C, "after truncated event R9");
    fclear(); fpre(); fhdr(4'h1, 12'h000);
    fword(16'h0001); fword(16'h0002); fword(16'h0003); fword(16'h0004); fbyte(8'h77);
    send_frame();
    chk("R9 stray byte still one record", n_rec, 1);
    chk("R9 stray byte no error", n_trunc, 0);
  endtask

  task automatic t_backpressure();
    logic [29:0] ns0;
    fclear(); fpre(); fhdr(4'h2, 12'h055);
    fword(16'h0100); fword(16'h0200); fword(16'h0300); fword(16'h0400);
    fword(16'h0500); fword(16'h2600);
    @(negedge clk); out_ready = 1'b0;
    send_frame();
    chk("R10 record pending", out_valid, 1);
    chk("R10 input stalled", in_ready, 0);
    ns0 = out_ns;
    repeat (4) @(negedge clk);
    chk("R10 held valid", out_valid, 1);
    chk("R10 held ns", out_ns, ns0);
    chk("R10 held ns value", out_ns, exp_ns(16'h0200, 16'h0100));
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", out_valid, 0);
    chk("R10 one record taken", n_rec, 1);
  endtask

  task automatic t_restart();
    fclear(); fpre(); fhdr(4'h2, 12'h000); fword(16'h1111); fword(16'h2222);
    fs[flen] = 1'b0;
    fbyte(8'h5A); fs[flen-1] = 1'b1;
    fbyte(8'hC3);
    fhdr(4'h1, 12'h0EE); fword(16'h0A0A); fword(16'h0B0B); fword(16'h0C0C); fword(16'h0D0D);
    send_frame();
    chk("R11 restart one record", n_rec, 1);
    chk("R11 restart kind", r_kind[0], 1);
    chk("R11 restart sec", r_sec[0], 32'h0D0D_0C0C);
    chk("R11 restart no error", n_trunc, 0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_little();
    t_tx_big();
    t_events();
    t_multi();
    t_unknown();
    t_trunc();
    t_backpressure();
    t_restart();
    report();
    $finish;
  end
endmodule